// File: doc/BRIEF.md
# Video Line Packet Formatter

This block turns a stream of raw pixel samples into framed raster lines for a sensor output link. Every line is wrapped in a three-word escape sequence, a line-type code, and a two-byte line number. It closes with a second escape sequence, an end-of-line code and one value byte. A frame is a fixed run of lines in this order: one status line, black lines, dark lines, active lines and one end-of-frame line. A programmable number of blank lines then follows before the next frame starts.

The status line carries no pixels. Its video slots hold a snapshot of sixteen configuration bytes, each followed by a separator, with filler around them. Its trailer holds a wrapping frame counter. The trailer of every other pixel-bearing line holds a line average. Pixels are pulled from an upstream show-ahead source through a read strobe, clamped out of the reserved code range, and emitted one word per cycle with a valid strobe. Idle padding can be placed after each trailer, so the spacing between a line's header and its trailer never changes.

Top module: `line_packet_fmt`

## Requirements
- R1: Each line begins with the escape words FFh, 00h, 00h, then the line-type code, then the line index within the frame as two bytes: {0, index[13:7]} followed by {0, index[6:0]}. The status line has index 0.
- R2: The line-type codes are A0h (status), A1h (black), A2h (dark), A3h (active), A4h (end-of-frame) and A5h (blank). Line 0 is the status line. Next come N_BLACK black lines, N_DARK dark lines, N_ACTIVE active lines and one end-of-frame line. The blank lines follow after that.
- R3: Black, dark and active lines assert pix_rd for exactly ACT_PIX consecutive cycles. They emit the sampled pixels in the order they were read, one word per cycle.
- R4: A pixel whose upper eight bits are FFh is output as 3FBh (FEh in 8-bit mode). A pixel whose upper eight bits are 00h is output as 004h (01h in 8-bit mode). No pixel word can therefore start an escape.
- R5: The video portion of the status line is: two filler words (07h); then, for each of the 16 configuration bytes in ascending order, the byte followed by the separator 5Ah; then filler up to ACT_PIX words.
- R6: A configuration byte whose bit in reg_used is 0 is replaced on the status line by byte 0.
- R7: Each line ends with FFh, 00h, 00h, B0h and one value byte. On active, black and dark lines this byte is bits [9:2] of the truncated mean of that line's raw pixels. On the status line it is the frame counter. On end-of-frame and blank lines it is 00h.
- R8: The frame counter is 0 in the first frame after reset, increments by one per frame, and wraps from FFh to 00h.
- R9: After each trailer, pad_len idle cycles (out_valid low) are inserted. Words inside a line are contiguous, so the header-to-trailer spacing is constant.
- R10: After the end-of-frame line, blank_len blank lines follow (type A5h, video filled with 07h, no pixel reads), before the next status line. pad_len and blank_len are captured at the start of each frame.
- R11: In 10-bit mode (mode10=1), every non-pixel byte b is output as {b, 00}. In 8-bit mode it is output as {00, b}, and pixels are output as {00, pixel[9:2]} after clamping.
- R12: After reset, out_valid and pix_rd stay low until run is high. A frame that has started always completes. With run low at a frame's end, no further words are produced.
- R13: End-of-frame and blank lines fill their ACT_PIX video words with 07h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start frames; sampled at each frame boundary |
| mode10 | input | 1 | 1: 10-bit words, 0: 8-bit words |
| pad_len | input | PAD_W | Idle cycles after each line trailer |
| blank_len | input | BLANK_W | Blank lines after the end-of-frame line |
| reg_img | input | 8*N_REGS | Configuration bytes shown on the status line |
| reg_used | input | N_REGS | Per-byte valid mask for the status snapshot |
| pix_rd | output | 1 | Pixel read strobe to the upstream source |
| pix_in | input | 10 | Pixel sample, valid in the cycle pix_rd is high |
| out_valid | output | 1 | Output word valid |
| out_data | output | 10 | Output word |

## Verification
Some properties are checked by assertions on every cycle. No pixel word can carry an escape prefix, and code words keep their two low bits clear in 10-bit mode. The frame counter only ever steps by one. Every video portion lasts exactly ACT_PIX cycles, and padding never overruns its length. Other behaviour can only be shown by the bench scenarios, which compare whole frames word by word:
- the exact order of line types and line numbers
- the status snapshot, including the substitution of byte 0
- the averages
- the extra blank lines
- the idle gaps between lines
- stopping cleanly at a frame end
- the counter's wrap after 256 frames

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    localparam int PIX_W = 10;

    localparam logic [7:0] ESC_LEAD  = 8'hFF;
    localparam logic [7:0] ESC_ZERO  = 8'h00;
    localparam logic [7:0] EOL_CODE  = 8'hB0;
    localparam logic [7:0] STAT_SEP  = 8'h5A;
    localparam logic [7:0] FILL_CODE = 8'h07;
    localparam logic [7:0] TYPE_BASE = 8'hA0;

    localparam int HEAD_LEN  = 6;
    localparam int TRAIL_LEN = 5;

    typedef enum logic [2:0] {
        LT_STATUS = 3'd0,
        LT_BLACK  = 3'd1,
        LT_DARK   = 3'd2,
        LT_ACTIVE = 3'd3,
        LT_EOF    = 3'd4,
        LT_BLANK  = 3'd5
    } ltype_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HEAD  = 3'd1,
        PH_VIDEO = 3'd2,
        PH_TRAIL = 3'd3,
        PH_PAD   = 3'd4
    } phase_e;

    typedef struct packed {
        logic             valid;
        logic             is_pix;
        logic [PIX_W-1:0] data;
    } word_t;

    function automatic logic [7:0] type_code(input ltype_e t);
        return TYPE_BASE | {5'd0, t};
    endfunction

    function automatic logic [PIX_W-1:0] code_word(input logic [7:0] b, input logic m10);
        return m10 ? {b, 2'b00} : {2'b00, b};
    endfunction

    function automatic logic [PIX_W-1:0] pix_word(input logic [PIX_W-1:0] p, input logic m10);
        logic [7:0] top;
        top = p[PIX_W-1:2];
        if (m10) begin
            if (top == 8'hFF)      return 10'h3FB;
            else if (top == 8'h00) return 10'h004;
            else                   return p;
        end else begin
            if (top == 8'hFF)      return {2'b00, 8'hFE};
            else if (top == 8'h00) return {2'b00, 8'h01};
            else                   return {2'b00, top};
        end
    endfunction

    function automatic logic carries_pixels(input ltype_e t);
        return (t == LT_BLACK) || (t == LT_DARK) || (t == LT_ACTIVE);
    endfunction

endpackage

// File: rtl/vlf_seq.sv
module vlf_seq
    import vlf_pkg::*;
#(
    parameter int ACT_PIX  = 64,
    parameter int N_BLACK  = 1,
    parameter int N_DARK   = 1,
    parameter int N_ACTIVE = 2,
    parameter int PAD_W    = 8,
    parameter int BLANK_W  = 4,
    parameter int LN_W     = 14,
    localparam int CNT_W   = ($clog2(ACT_PIX) > PAD_W) ? $clog2(ACT_PIX) : PAD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PAD_W-1:0]   pad_len,
    input  logic [BLANK_W-1:0] blank_len,
    output phase_e             phase,
    output ltype_e             ltype,
    output logic [CNT_W-1:0]   cnt,
    output logic [LN_W-1:0]    line_num,
    output logic [7:0]         frame_cnt,
    output logic               pix_rd
);

    localparam int LAST_BLACK = N_BLACK;
    localparam int LAST_DARK  = N_BLACK + N_DARK;
    localparam int LAST_ACT   = N_BLACK + N_DARK + N_ACTIVE;
    localparam int EOF_LINE   = LAST_ACT + 1;

    logic [PAD_W-1:0]   pad_lat;
    logic [BLANK_W-1:0] blank_lat;
    logic               line_done;
    logic               last_line;
    logic [CNT_W-1:0]   pad_end;

    always_comb begin
        if (line_num == '0)                          ltype = LT_STATUS;
        else if (line_num <= LN_W'(LAST_BLACK))      ltype = LT_BLACK;
        else if (line_num <= LN_W'(LAST_DARK))       ltype = LT_DARK;
        else if (line_num <= LN_W'(LAST_ACT))        ltype = LT_ACTIVE;
        else if (line_num == LN_W'(EOF_LINE))        ltype = LT_EOF;
        else                                         ltype = LT_BLANK;
    end

    assign pad_end   = CNT_W'(pad_lat) - CNT_W'(1);
    assign last_line = (line_num == LN_W'(EOF_LINE) + LN_W'(blank_lat));
    assign line_done = ((phase == PH_TRAIL) && (cnt == CNT_W'(TRAIL_LEN-1)) && (pad_lat == '0))
                    || ((phase == PH_PAD) && (cnt == pad_end));
    assign pix_rd    = (phase == PH_VIDEO) && carries_pixels(ltype);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            line_num  <= '0;
            frame_cnt <= '0;
            pad_lat   <= '0;
            blank_lat <= '0;
        end else begin
            if ((phase == PH_TRAIL) && (cnt == CNT_W'(TRAIL_LEN-1)) && (ltype == LT_STATUS))
                frame_cnt <= frame_cnt + 8'd1;
            if (line_done) begin
                cnt <= '0;
                if (last_line) begin
                    line_num <= '0;
                    if (run) begin
                        phase     <= PH_HEAD;
                        pad_lat   <= pad_len;
                        blank_lat <= blank_len;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end else begin
                    phase    <= PH_HEAD;
                    line_num <= line_num + LN_W'(1);
                end
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        if (run) begin
                            phase     <= PH_HEAD;
                            cnt       <= '0;
                            line_num  <= '0;
                            pad_lat   <= pad_len;
                            blank_lat <= blank_len;
                        end
                    end
                    PH_HEAD: begin
                        if (cnt == CNT_W'(HEAD_LEN-1)) begin
                            phase <= PH_VIDEO;
                            cnt   <= '0;
                        end else cnt <= cnt + CNT_W'(1);
                    end
                    PH_VIDEO: begin
                        if (cnt == CNT_W'(ACT_PIX-1)) begin
                            phase <= PH_TRAIL;
                            cnt   <= '0;
                        end else cnt <= cnt + CNT_W'(1);
                    end
                    PH_TRAIL: begin
                        if (cnt == CNT_W'(TRAIL_LEN-1)) begin
                            phase <= PH_PAD;
                            cnt   <= '0;
                        end else cnt <= cnt + CNT_W'(1);
                    end
                    PH_PAD:  cnt <= cnt + CNT_W'(1);
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    AST_FCNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt != $past(frame_cnt)) |-> (frame_cnt == $past(frame_cnt) + 8'd1)); // R8

    AST_VIDEO_SPAN: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_TRAIL) && (cnt == '0)) |->
        (($past(phase) == PH_VIDEO) && ($past(cnt) == CNT_W'(ACT_PIX-1)))); // R3

    AST_PAD_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAD) |-> (cnt < CNT_W'(pad_lat))); // R9

endmodule

// File: rtl/vlf_stat.sv
module vlf_stat
    import vlf_pkg::*;
#(
    parameter int N_REGS  = 16,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(N_REGS),
    localparam int STAT_END = 2 + 2 * N_REGS
) (
    input  logic [8*N_REGS-1:0] reg_img,
    input  logic [N_REGS-1:0]   reg_used,
    input  logic [CNT_W-1:0]    slot,
    output logic [7:0]          stat_byte
);

    logic [7:0]       eff [N_REGS];
    logic [CNT_W-1:0] rel;
    logic [IDX_W-1:0] idx;

    for (genvar i = 0; i < N_REGS; i++) begin : g_eff
        assign eff[i] = reg_used[i] ? reg_img[8*i +: 8] : reg_img[7:0];
    end

    assign rel = slot - CNT_W'(2);
    assign idx = rel[IDX_W:1];

    always_comb begin
        if (slot < CNT_W'(2) || slot >= CNT_W'(STAT_END))
            stat_byte = FILL_CODE;
        else if (rel[0])
            stat_byte = STAT_SEP;
        else
            stat_byte = eff[idx];
    end

endmodule

// File: rtl/vlf_avg.sv
module vlf_avg
    import vlf_pkg::*;
#(
    parameter int ACT_PIX = 64,
    localparam int LOG2   = $clog2(ACT_PIX),
    localparam int SUM_W  = PIX_W + LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic [PIX_W-1:0] pix,
    output logic [7:0]       avg_byte
);

    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst || clr) sum <= '0;
        else if (add)   sum <= sum + SUM_W'(pix);
    end

    assign avg_byte = sum[SUM_W-1 -: 8];

endmodule

// File: rtl/line_packet_fmt.sv
module line_packet_fmt
    import vlf_pkg::*;
#(
    parameter int ACT_PIX  = 64,
    parameter int N_BLACK  = 1,
    parameter int N_DARK   = 1,
    parameter int N_ACTIVE = 2,
    parameter int N_REGS   = 16,
    parameter int PAD_W    = 8,
    parameter int BLANK_W  = 4,
    localparam int LN_W    = 14,
    localparam int CNT_W   = ($clog2(ACT_PIX) > PAD_W) ? $clog2(ACT_PIX) : PAD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                mode10,
    input  logic [PAD_W-1:0]    pad_len,
    input  logic [BLANK_W-1:0]  blank_len,
    input  logic [8*N_REGS-1:0] reg_img,
    input  logic [N_REGS-1:0]   reg_used,
    output logic                pix_rd,
    input  logic [9:0]          pix_in,
    output logic                out_valid,
    output logic [9:0]          out_data
);

    // The status payload must fit in the video portion: ACT_PIX >= 2 + 2*N_REGS.

    phase_e           phase;
    ltype_e           ltype;
    logic [CNT_W-1:0] cnt;
    logic [LN_W-1:0]  line_num;
    logic [7:0]       frame_cnt;
    logic [7:0]       stat_byte;
    logic [7:0]       avg_byte;
    word_t            nxt, cur;

    vlf_seq #(
        .ACT_PIX(ACT_PIX), .N_BLACK(N_BLACK), .N_DARK(N_DARK), .N_ACTIVE(N_ACTIVE),
        .PAD_W(PAD_W), .BLANK_W(BLANK_W), .LN_W(LN_W)
    ) seq_i (
        .clk(clk), .rst(rst), .run(run), .pad_len(pad_len), .blank_len(blank_len),
        .phase(phase), .ltype(ltype), .cnt(cnt), .line_num(line_num),
        .frame_cnt(frame_cnt), .pix_rd(pix_rd)
    );

    vlf_stat #(.N_REGS(N_REGS), .CNT_W(CNT_W)) stat_i (
        .reg_img(reg_img), .reg_used(reg_used), .slot(cnt), .stat_byte(stat_byte)
    );

    vlf_avg #(.ACT_PIX(ACT_PIX)) avg_i (
        .clk(clk), .rst(rst),
        .clr((phase == PH_HEAD) && (cnt == '0)),
        .add(pix_rd), .pix(pix_in), .avg_byte(avg_byte)
    );

    always_comb begin
        logic [7:0] b;
        b          = ESC_ZERO;
        nxt.valid  = 1'b0;
        nxt.is_pix = 1'b0;
        nxt.data   = '0;
        unique case (phase)
            PH_HEAD: begin
                nxt.valid = 1'b1;
                unique case (cnt)
                    CNT_W'(0): b = ESC_LEAD;
                    CNT_W'(3): b = type_code(ltype);
                    CNT_W'(4): b = {1'b0, line_num[13:7]};
                    CNT_W'(5): b = {1'b0, line_num[6:0]};
                    default:   b = ESC_ZERO;
                endcase
                nxt.data = code_word(b, mode10);
            end
            PH_VIDEO: begin
                nxt.valid = 1'b1;
                if (carries_pixels(ltype)) begin
                    nxt.is_pix = 1'b1;
                    nxt.data   = pix_word(pix_in, mode10);
                end else begin
                    b        = (ltype == LT_STATUS) ? stat_byte : FILL_CODE;
                    nxt.data = code_word(b, mode10);
                end
            end
            PH_TRAIL: begin
                nxt.valid = 1'b1;
                unique case (cnt)
                    CNT_W'(0): b = ESC_LEAD;
                    CNT_W'(3): b = EOL_CODE;
                    CNT_W'(4): begin
                        if (ltype == LT_STATUS)          b = frame_cnt;
                        else if (carries_pixels(ltype))  b = avg_byte;
                        else                             b = ESC_ZERO;
                    end
                    default:   b = ESC_ZERO;
                endcase
                nxt.data = code_word(b, mode10);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign out_valid = cur.valid;
    assign out_data  = cur.data;

    AST_PIX_NO_ESC: assert property (@(posedge clk) disable iff (rst)
        (cur.is_pix && mode10) |-> (out_data[9:2] != 8'hFF) && (out_data[9:2] != 8'h00)); // R4

    AST_PIX8_NO_ESC: assert property (@(posedge clk) disable iff (rst)
        (cur.is_pix && !mode10) |->
        (out_data[9:8] == 2'b00) && (out_data[7:0] != 8'hFF) && (out_data[7:0] != 8'h00)); // R4

    AST_CODE_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cur.is_pix && mode10) |-> (out_data[1:0] == 2'b00)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IDLE) |-> !out_valid); // R12

endmodule

// File: tb/line_packet_fmt_tb_top.sv
`timescale 1ns/1ps
module line_packet_fmt_tb_top;

    localparam int ACT_PIX = 64;
    localparam int LINE_W  = 6 + ACT_PIX + 5;
    localparam int VLINES  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        mode10 = 1'b1;
    logic [7:0]  pad_len = '0;
    logic [3:0]  blank_len = '0;
    logic [127:0] reg_img;
    logic [15:0] reg_used = 16'hFFFF;
    logic        pix_rd;
    logic [9:0]  pix_in;
    logic        out_valid;
    logic [9:0]  out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pat    = 0;
    int src_idx = 0;
    int exp_fc = 0;
    bit done = 0;
    logic [7:0] regb [16];

    int    cap_d[$];
    int    cap_t[$];
    int    exp_d[$];
    string exp_g[$];

    always #4 clk = ~clk;

    line_packet_fmt dut_i (
        .clk(clk), .rst(rst), .run(run), .mode10(mode10), .pad_len(pad_len),
        .blank_len(blank_len), .reg_img(reg_img), .reg_used(reg_used),
        .pix_rd(pix_rd), .pix_in(pix_in), .out_valid(out_valid), .out_data(out_data)
    );

    always_comb for (int i = 0; i < 16; i++) reg_img[8*i +: 8] = regb[i];

    function automatic int pval(input int i);
        int k;
        if (pat == 1) begin
            k = i % 4;
            return (k == 0) ? 0 : (k == 1) ? 'h3FF : (k == 2) ? 3 : 'h3FD;
        end else if (pat == 2) return i & 'h3FF;
        return (i * 37 + 11) & 'h3FF;
    endfunction

    assign pix_in = 10'(pval(src_idx));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) src_idx <= 0;
        else if (pix_rd) src_idx <= src_idx + 1;
    end

    always @(negedge clk) if (out_valid) begin
        cap_d.push_back(int'(out_data));
        cap_t.push_back(cyc);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int cw(input int b);
        return mode10 ? ((b & 'hFF) << 2) : (b & 'hFF);
    endfunction

    function automatic int pw(input int p);
        int t = (p >> 2) & 'hFF;
        if (mode10) return (t == 'hFF) ? 'h3FB : (t == 0) ? 'h004 : p;
        return (t == 'hFF) ? 'hFE : (t == 0) ? 'h01 : t;
    endfunction

    function automatic void put(input int d, input string g);
        exp_d.push_back(d);
        exp_g.push_back(g);
    endfunction

    task automatic build_frame(input int fc, inout int px);
        for (int ln = 0; ln < VLINES + int'(blank_len); ln++) begin
            int t   = (ln == 0) ? 0 : (ln == 1) ? 1 : (ln == 2) ? 2 : (ln <= 4) ? 3 : (ln == 5) ? 4 : 5;
            int sum = 0;
            put(cw('hFF), "R1"); put(cw(0), "R1"); put(cw(0), "R1");
            put(cw('hA0 + t), "R2");
            put(cw((ln >> 7) & 'h7F), "R1"); put(cw(ln & 'h7F), "R1");
            for (int s = 0; s < ACT_PIX; s++) begin
                if (t >= 1 && t <= 3) begin
                    int p = pval(px);
                    sum += p; px++;
                    put(pw(p), "R3/R4");
                end else if (t == 0) begin
                    if (s < 2 || s >= 34) put(cw('h07), "R5");
                    else if (((s - 2) % 2) == 1) put(cw('h5A), "R5");
                    else begin
                        int j = (s - 2) / 2;
                        put(cw(reg_used[j] ? regb[j] : regb[0]), "R6");
                    end
                end else put(cw('h07), "R13");
            end
            put(cw('hFF), "R7"); put(cw(0), "R7"); put(cw(0), "R7"); put(cw('hB0), "R7");
            if (t == 0) put(cw(fc & 'hFF), "R8");
            else if (t <= 3) put(cw(((sum / ACT_PIX) >> 2) & 'hFF), "R7");
            else put(cw(0), "R10");
        end
    endtask

    task automatic run_frames(input int n, input string who);
        int fw = (VLINES + int'(blank_len)) * LINE_W;
        int px = src_idx;
        cap_d.delete(); cap_t.delete(); exp_d.delete(); exp_g.delete();
        for (int k = 0; k < n; k++) build_frame(exp_fc + k, px);
        @(posedge clk); #1 run = 1'b1;
        while (cap_d.size() < (n - 1) * fw + 1) @(posedge clk);
        #1 run = 1'b0;
        while (cap_d.size() < n * fw) @(posedge clk);
        repeat (300) @(posedge clk);
        chk(cap_d.size() == n * fw, {who, " R12 word count"}, cap_d.size(), n * fw);
        for (int i = 0; i < exp_d.size() && i < cap_d.size(); i++)
            chk(cap_d[i] == exp_d[i], {who, " ", exp_g[i], $sformatf(" word %0d", i)}, cap_d[i], exp_d[i]);
        exp_fc += n;
    endtask

    task automatic t_reset;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(!out_valid && !pix_rd, "R12 idle after reset", {out_valid, pix_rd}, 0);
        end
    endtask

    task automatic t_basic;
        mode10 = 1'b1; pat = 0; reg_used = 16'hFFFF;
        for (int i = 0; i < 16; i++) regb[i] = 8'(i * 29 + 3);
        run_frames(2, "basic10");
    endtask

    task automatic t_clamp;
        pat = 1; mode10 = 1'b1;
        run_frames(1, "clamp10");
        mode10 = 1'b0; pat = 2;
        run_frames(1, "ramp8 R11");
        pat = 1;
        run_frames(1, "clamp8");
        mode10 = 1'b1;
    endtask

    task automatic t_unused;
        pat = 0; reg_used = 16'h5A3C; regb[0] = 8'hC7;
        run_frames(1, "unused R6");
        reg_used = 16'hFFFF;
    endtask

    task automatic t_pad;
        pad_len = 8'd3;
        run_frames(2, "pad");
        for (int i = 1; i < cap_t.size(); i++) begin
            int gap = (i % LINE_W == 0) ? 4 : 1;
            chk(cap_t[i] - cap_t[i-1] == gap, $sformatf("R9 gap before word %0d", i),
                cap_t[i] - cap_t[i-1], gap);
        end
        pad_len = 8'd0;
    endtask

    task automatic t_blank;
        blank_len = 4'd3;
        run_frames(2, "blank R10");
        blank_len = 4'd0;
    endtask

    task automatic t_wrap;
        int n = 257 - exp_fc;
        run_frames(n, "wrap R8");
        chk(exp_fc == 257, "R8 frames run", exp_fc, 257);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regb[i] = 8'h00;
        t_reset();
        t_basic();
        t_clamp();
        t_unused();
        t_pad();
        t_blank();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule